// File: doc/BRIEF.md
# Multi-Domain Ratio Clock Divider

The block turns one fast reference clock into four clock-enable streams, one each for the core, the high-speed bus, the low-speed peripheral bus and the memory domain. A 32-bit control register holds a packed 4-bit ratio code per domain. A small decoder maps each code onto a non-linear ratio set: 1, 2, 3, 4, 6, 8, 12, 16, 24, 32. Each domain has a generator that raises its enable for one reference cycle in every R cycles, where R is the decoded ratio. Logic in each domain advances only on cycles where its enable is high, so no gated clock is needed.

Software reaches the register through a masked write port. Each write merges the masked bits into the held value. The ratio fields are only updated while a change-enable bit in the register is set. A new ratio is loaded into a generator only at that generator's terminal count, so a running period is never cut short. Two further register bits control the secondary outputs. One gates the memory enable out to an external clock-output pin. The other turns an always-high reference strobe into a half-rate strobe.

Each domain generator is a three-state machine:
- `S_ONE` is divide-by-1, with the enable held high.
- `S_RUN` counts down with the enable low.
- `S_LAST` is the terminal cycle, with the enable high.

The generator moves between these states as follows:
- From `S_ONE` or `S_LAST`, it loads the decoded ratio R. It goes to `S_ONE` when R is 1. Otherwise it goes to `S_RUN` with the counter preset to R-2.
- In `S_RUN`, it counts down. It moves to `S_LAST` when the counter reaches zero.

Top module: `ratio_clk_div`

## Requirements
- R1: Ratio codes 0 to 9 select divide ratios 1, 2, 3, 4, 6, 8, 12, 16, 24 and 32 in that order. For a ratio R, the domain enable is high on exactly one reference cycle in every R.
- R2: Any ratio code from 10 to 15 divides by 32.
- R3: Register bits 3:0 hold the core code, bits 7:4 the high-speed bus code, bits 11:8 the low-speed peripheral code and bits 15:12 the memory code. Each domain follows only its own field.
- R4: On a write, each register bit whose mask bit is 1 takes the data bit, and every other bit keeps its value. `rd_data` always shows the register, and with no write the register holds.
- R5: Bits 15:0 change only on a write made while the stored bit 22 (change-enable) is 1. While bit 22 is 0, writes leave the ratio fields and the enable periods unchanged, and the other masked bits are still written.
- R6: A domain adopts a changed code only after the terminal pulse of its current period. A period in progress is never shortened.
- R7: At ratio 1 the enable stays high on every cycle. At any larger ratio each pulse is exactly one cycle wide.
- R8: When register bit 30 is 0, `mem_ck_out` is low. When bit 30 is 1, `mem_ck_out` equals `en_mem`.
- R9: When register bit 21 is 0, `half_en` is high on every cycle. When bit 21 is 1, `half_en` is high on alternate cycles.
- R10: A synchronous active-high reset clears the register to zero. All four enables are then high (divide by 1), `mem_ck_out` is low and `half_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| wr_mask | input | 32 | Per-bit write mask, 1 = update |
| rd_data | output | 32 | Current register value |
| en_core | output | 1 | Core domain clock enable |
| en_hbus | output | 1 | High-speed bus clock enable |
| en_pbus | output | 1 | Low-speed peripheral clock enable |
| en_mem | output | 1 | Memory domain clock enable |
| mem_ck_out | output | 1 | External memory clock output enable |
| half_en | output | 1 | Reference strobe, full or half rate |

## Verification
Every code from 0 to 15 is applied to each of the four domains in turn. For each code the bench counts the pulses in a 192-cycle window. Because 192 is a multiple of every ratio, the count is exact for every ratio. This separates neighbouring table entries, exposes a wrong saturation value on codes 10 to 15, and exposes any field shifted onto the wrong domain.

The directed cases target specific faults:
- A change from ratio 32 to ratio 1 is made just after a pulse. This shows whether the period is shortened or the new code is adopted early.
- A write with change-enable clear shows whether the ratio fields are protected while the other bits are still updated.
- Mask patterns that touch only unrelated bits show whether the merge preserves unmasked bits.

// File: rtl/ratio_div_pkg.sv
package ratio_div_pkg;

    localparam int CODE_W   = 4;
    localparam int NUM_DOM  = 4;
    localparam int RATIO_W  = 6;
    localparam int FIELD_W  = CODE_W * NUM_DOM;
    localparam int CHG_BIT  = 22;
    localparam int HALF_BIT = 21;
    localparam int OE_BIT   = 30;

    typedef enum logic [1:0] {
        S_ONE  = 2'd0,
        S_RUN  = 2'd1,
        S_LAST = 2'd2
    } div_state_t;

    // Non-linear ratio set; codes past the table saturate at the top ratio.
    function automatic logic [RATIO_W-1:0] decode_ratio(input logic [CODE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        unique case (code)
            4'd0:    r = 6'd1;
            4'd1:    r = 6'd2;
            4'd2:    r = 6'd3;
            4'd3:    r = 6'd4;
            4'd4:    r = 6'd6;
            4'd5:    r = 6'd8;
            4'd6:    r = 6'd12;
            4'd7:    r = 6'd16;
            4'd8:    r = 6'd24;
            default: r = 6'd32;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ratio_ctrl_reg.sv
module ratio_ctrl_reg
    import ratio_div_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_mask,
    output logic [DATA_W-1:0] reg_q
);

    logic [DATA_W-1:0] merged;

    always_comb begin
        merged = (reg_q & ~wr_mask) | (wr_data & wr_mask);
        if (!reg_q[CHG_BIT]) begin
            merged[FIELD_W-1:0] = reg_q[FIELD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else if (wr_en) begin
            reg_q <= merged;
        end
    end

endmodule

// File: rtl/ratio_gen.sv
module ratio_gen
    import ratio_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    output logic              en
);

    div_state_t         state, state_n;
    logic [RATIO_W-1:0] cnt, cnt_n;
    logic [RATIO_W-1:0] ratio;

    assign ratio = decode_ratio(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_ONE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            S_ONE, S_LAST: begin
                if (ratio == RATIO_W'(1)) begin
                    state_n = S_ONE;
                    cnt_n   = '0;
                end else begin
                    state_n = S_RUN;
                    cnt_n   = ratio - RATIO_W'(2);
                end
            end
            S_RUN: begin
                if (cnt == '0) begin
                    state_n = S_LAST;
                end else begin
                    cnt_n = cnt - RATIO_W'(1);
                end
            end
            default: begin
                state_n = S_ONE;
                cnt_n   = '0;
            end
        endcase
    end

    always_comb begin
        en = (state != S_RUN);
    end

endmodule

// File: rtl/half_rate_gen.sv
module half_rate_gen (
    input  logic clk,
    input  logic rst,
    input  logic half_sel,
    output logic strobe
);

    logic phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b1;
        end else begin
            phase <= ~phase;
        end
    end

    always_comb begin
        strobe = half_sel ? phase : 1'b1;
    end

endmodule

// File: rtl/ratio_clk_div.sv
module ratio_clk_div
    import ratio_div_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_mask,
    output logic [DATA_W-1:0] rd_data,
    output logic              en_core,
    output logic              en_hbus,
    output logic              en_pbus,
    output logic              en_mem,
    output logic              mem_ck_out,
    output logic              half_en
);

    logic [DATA_W-1:0]  ctrl_q;
    logic [NUM_DOM-1:0] dom_en;

    ratio_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .reg_q   (ctrl_q)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        ratio_gen u_gen (
            .clk  (clk),
            .rst  (rst),
            .code (ctrl_q[d*CODE_W +: CODE_W]),
            .en   (dom_en[d])
        );
    end

    half_rate_gen u_half (
        .clk      (clk),
        .rst      (rst),
        .half_sel (ctrl_q[HALF_BIT]),
        .strobe   (half_en)
    );

    assign rd_data    = ctrl_q;
    assign en_core    = dom_en[0];
    assign en_hbus    = dom_en[1];
    assign en_pbus    = dom_en[2];
    assign en_mem     = dom_en[3];
    assign mem_ck_out = ctrl_q[OE_BIT] & dom_en[3];

endmodule

// File: rtl/ratio_div_chk.sv
module ratio_div_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_mask,
    input logic [31:0] rd_data,
    input logic        en_mem,
    input logic        mem_ck_out,
    input logic        half_en
);

    // R4
    unmasked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (((rd_data ^ $past(rd_data)) & ~$past(wr_mask)) == 32'h0));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data));

    // R5
    field_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_data[22]) |=> (rd_data[15:0] == $past(rd_data[15:0])));

    // R8
    mem_out_follow_chk: assert property (@(posedge clk) disable iff (rst)
        mem_ck_out |-> en_mem);

    // R8
    mem_out_off_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_data[30] |-> !mem_ck_out);

    // R9
    half_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[21] && $past(rd_data[21])) |-> (half_en != $past(half_en)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (rd_data == 32'h0));

endmodule

bind ratio_clk_div ratio_div_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_mask    (wr_mask),
    .rd_data    (rd_data),
    .en_mem     (en_mem),
    .mem_ck_out (mem_ck_out),
    .half_en    (half_en)
);

// File: tb/ratio_clk_div_tb.sv
`timescale 1ns/1ps
module ratio_clk_div_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] wr_mask = '0;
    logic [31:0] rd_data;
    logic        en_core, en_hbus, en_pbus, en_mem, mem_ck_out, half_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expected ratio per code 0..15 (R1, R2)
    localparam int EXP_RATIO [16] = '{1, 2, 3, 4, 6, 8, 12, 16, 24, 32,
                                      32, 32, 32, 32, 32, 32};
    localparam int WIN = 192;

    always #2 clk = ~clk;

    ratio_clk_div u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
        .rd_data(rd_data), .en_core(en_core), .en_hbus(en_hbus), .en_pbus(en_pbus),
        .en_mem(en_mem), .mem_ck_out(mem_ck_out), .half_en(half_en)
    );

    logic [3:0] en_v;
    assign en_v = {en_mem, en_pbus, en_hbus, en_core};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] d, input logic [31:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_mask = m;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; wr_mask = '0;
    endtask

    task automatic count_pulses(input int dom, output int n);
        n = 0;
        for (int k = 0; k < WIN; k++) begin
            @(negedge clk);
            if (en_v[dom]) n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int gap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(rd_data == 32'h0, "R10 reg", int'(rd_data), 0);
        check(en_v == 4'hF && !mem_ck_out && half_en, "R10 outputs",
              int'({en_v, mem_ck_out, half_en}), 'h3D);
        count_pulses(0, n);
        check(n == WIN, "R7 ratio1 continuous", n, WIN);

        // R5: change-enable clear, field write ignored, other bits still written
        reg_write(32'h4000_0005, 32'h4000_000F);
        check(rd_data == 32'h4000_0000, "R5 field locked", int'(rd_data), 'h4000_0000);
        count_pulses(0, n);
        check(n == WIN, "R5 core period unchanged", n, WIN);

        // R4: masked merge
        reg_write(32'h0400_0000, 32'h0400_0000);
        check(rd_data == 32'h4400_0000, "R4 merge set", int'(rd_data), 'h4400_0000);
        reg_write(32'hFFFF_FFFF, 32'h0000_0000);
        check(rd_data == 32'h4400_0000, "R4 zero mask", int'(rd_data), 'h4400_0000);
        reg_write(32'h0000_0000, 32'h0400_0000);
        check(rd_data == 32'h4000_0000, "R4 merge clear", int'(rd_data), 'h4000_0000);

        // enable change (bit 22), disable OE for now
        reg_write(32'h0040_0000, 32'h4040_0000);
        check(rd_data == 32'h0040_0000, "R4 chg set", int'(rd_data), 'h0040_0000);

        // table walk: every code on every domain (R1, R2, R3)
        for (int d = 0; d < 4; d++) begin
            for (int c = 0; c < 16; c++) begin
                reg_write(32'(c) << (4*d), 32'hF << (4*d));
                check(((rd_data >> (4*d)) & 32'hF) == 32'(c), "R3 field", int'((rd_data >> (4*d)) & 32'hF), c);
                repeat (70) @(negedge clk);
                count_pulses(d, n);
                check(n == WIN / EXP_RATIO[c], c < 10 ? "R1 ratio" : "R2 saturate", n, WIN / EXP_RATIO[c]);
            end
            reg_write(32'h0, 32'hF << (4*d));
            repeat (70) @(negedge clk);
            count_pulses(d, n);
            check(n == WIN, "R3 domain back to 1", n, WIN);
        end

        // R7: pulse width one cycle at ratio 2
        reg_write(32'h0000_0100, 32'h0000_0F00);
        repeat (10) @(negedge clk);
        begin
            int hh = 0;
            logic prev = 1'b0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (en_pbus && prev) hh++;
                prev = en_pbus;
            end
            check(hh == 0, "R7 single-cycle pulse", hh, 0);
        end

        // R8: OE off -> low; on -> follows en_mem
        reg_write(32'h0000_2000, 32'h0000_F000);
        repeat (40) @(negedge clk);
        count_pulses(3, n);
        begin
            int m = 0;
            for (int k = 0; k < WIN; k++) begin
                @(negedge clk);
                if (mem_ck_out) m++;
            end
            check(m == 0, "R8 out low when disabled", m, 0);
        end
        reg_write(32'h4000_0000, 32'h4000_0000);
        begin
            int m = 0;
            int mism = 0;
            for (int k = 0; k < WIN; k++) begin
                @(negedge clk);
                if (mem_ck_out) m++;
                if (mem_ck_out != en_mem) mism++;
            end
            check(m == WIN / 3 && mism == 0, "R8 out follows mem", m, WIN / 3);
        end

        // R6: 32 -> 1 change just after a pulse keeps the full period
        reg_write(32'h0000_9000, 32'h0000_F000);
        repeat (70) @(negedge clk);
        n = 0;
        while (!en_mem && n < 100) begin
            @(negedge clk);
            n++;
        end
        wr_en = 1'b1; wr_data = 32'h0; wr_mask = 32'h0000_F000;
        gap = 0;
        for (int k = 1; k <= 100; k++) begin
            @(negedge clk);
            if (k == 1) begin wr_en = 1'b0; wr_mask = '0; end
            if (en_mem) begin gap = k; break; end
        end
        check(gap == 32, "R6 period not shortened", gap, 32);
        @(negedge clk);
        check(en_mem == 1'b1, "R6 new ratio after terminal", int'(en_mem), 1);

        // R9: half-rate strobe
        begin
            int hi = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (half_en) hi++;
            end
            check(hi == 20, "R9 full rate", hi, 20);
        end
        reg_write(32'h0020_0000, 32'h0020_0000);
        begin
            int hi = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (half_en) hi++;
            end
            check(hi == 10, "R9 half rate", hi, 10);
        end

        // R10: reset again mid-run
        reg_write(32'h0000_5555, 32'h0000_FFFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(rd_data == 32'h0 && en_v == 4'hF && !mem_ck_out && half_en,
              "R10 reset mid-run", int'(rd_data), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule